// File: doc/BRIEF.md
# Per-Module Clock Gate Controller

This block produces a separate gated clock for each of 32 system and peripheral modules in a microcontroller subsystem. Software programs two kinds of gating per module through a small register interface. A forced-off bit stops the module clock unconditionally. A sleep-off bit stops the clock only while the CPU is asleep after a wait-for-interrupt or wait-for-event instruction. When the CPU wakes, clocks that were stopped only by the sleep-off mechanism run again without any software action.

The modules fall into four groups of eight: subsystem modules, peripheral bus clocks, security modules and miscellaneous clocks. Each group has its own forced-off register and its own sleep-off register. A read-only status register per group reports the effective enable of each module. The CPU sleep flag arrives from another clock domain and passes through a two-flop synchroniser. Each clock output comes from a cell with a low-transparent latch followed by an AND gate, so an enable change never cuts a pulse short.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset every forced-off and sleep-off bit reads 0, every status bit reads 1, and every module clock runs.
- R2: A set forced-off bit stops that module's clock from the cycle after the write, whether or not the CPU sleeps.
- R3: A module whose sleep-off bit is set and whose forced-off bit is clear is stopped while the synchronised CPU sleep flag is 1, and runs while it is 0.
- R4: A forced-off module stays stopped when the CPU wakes; its sleep-off bit has no effect on its enable.
- R5: When the CPU sleep flag falls, every module not forced off runs again with no register write.
- R6: A change of the CPU sleep input reaches the enables after exactly two rising clock edges; after one edge the enables are unchanged.
- R7: Register map on a 4-bit address: addresses 0 to 3 are the forced-off registers of groups 0 to 3, addresses 4 to 7 are the sleep-off registers of groups 0 to 3, and addresses 8 to 11 are the read-only status of groups 0 to 3. Bit i of group g is module 8*g+i, and a bit value of 1 means off (control) or running (status). Written values read back unchanged.
- R8: Writes to addresses 8 to 15 are ignored, and reads of addresses 12 to 15 return 0.
- R9: While a module's enable is 1 its clock output follows the input clock; while it is 0 the output is held low. An enable change takes hold only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gating clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sleep_i | input | 1 | CPU sleep flag, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| mod_clk | output | 32 | Gated clock for each module |

## Verification
The assertions assume that the CPU sleep input is held steady for at least two clock edges around each change. They also assume that it is quiet while reset is released. Without these conditions the synchroniser's two-edge delay would not be visible. The bench changes the sleep input only on a falling clock edge and then waits at least two full cycles before the next change. Register writes arrive one at a time, also on falling edges. The random part of the bench mixes writes to all eight control addresses with sleep changes. The directed part covers all eight combinations of forced-off, sleep-off and CPU sleep on single modules, and also covers the ignored and unused addresses.

// File: rtl/cg_pkg.sv
package cg_pkg;
    localparam int NUM_GRP = 4;
    localparam int GRP_W   = 8;
    localparam int NUM_MOD = NUM_GRP * GRP_W;
    localparam int ADDR_W  = 4;
    localparam int GSEL_W  = $clog2(NUM_GRP);

    typedef enum logic [1:0] {
        BANK_FORCE = 2'd0,
        BANK_SOFF  = 2'd1,
        BANK_STAT  = 2'd2,
        BANK_NONE  = 2'd3
    } bank_e;

    typedef struct packed {
        logic [NUM_MOD-1:0] force_off;
        logic [NUM_MOD-1:0] sleep_off;
    } cg_ctrl_t;

    function automatic bank_e bank_of(input logic [ADDR_W-1:0] a);
        return bank_e'(a[ADDR_W-1 -: 2]);
    endfunction

    function automatic logic [GSEL_W-1:0] group_of(input logic [ADDR_W-1:0] a);
        return a[GSEL_W-1:0];
    endfunction
endpackage

// File: rtl/cg_regfile.sv
module cg_regfile
    import cg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [GRP_W-1:0]      wr_data,
    output cg_ctrl_t              ctrl
);
    logic [NUM_GRP-1:0][GRP_W-1:0] force_q;
    logic [NUM_GRP-1:0][GRP_W-1:0] soff_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q <= '0;
            soff_q  <= '0;
        end else if (wr_en) begin
            case (bank_of(wr_addr))
                BANK_FORCE: force_q[group_of(wr_addr)] <= wr_data;
                BANK_SOFF:  soff_q[group_of(wr_addr)]  <= wr_data;
                default: ;
            endcase
        end
    end

    assign ctrl.force_off = force_q;
    assign ctrl.sleep_off = soff_q;

    p_ro_bank_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[ADDR_W-1]) |=> $stable(force_q) && $stable(soff_q));
endmodule

// File: rtl/cg_sleep_sync.sv
module cg_sleep_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            hold_q <= meta_q;
        end
    end

    assign sync_o = hold_q;
endmodule

// File: rtl/cg_enable_logic.sv
module cg_enable_logic
    import cg_pkg::*;
(
    input  cg_ctrl_t           ctrl,
    input  logic               cpu_asleep,
    output logic [NUM_MOD-1:0] en
);
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        always_comb begin
            if (ctrl.force_off[m])
                en[m] = 1'b0;
            else if (ctrl.sleep_off[m] && cpu_asleep)
                en[m] = 1'b0;
            else
                en[m] = 1'b1;
        end
    end
endmodule

// File: rtl/cg_clk_cell.sv
module cg_clk_cell (
    input  logic clk,
    input  logic en_i,
    output logic gclk_o
);
    logic en_l;

    always_latch begin
        if (!clk)
            en_l = en_i;
    end

    assign gclk_o = clk & en_l;
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
    import cg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_sleep_i,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [GRP_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [GRP_W-1:0]    rd_data,
    output logic [NUM_MOD-1:0]  mod_clk
);
    cg_ctrl_t           ctrl;
    logic               slp_sync;
    logic [NUM_MOD-1:0] en_vec;
    logic [NUM_GRP-1:0][GRP_W-1:0] force_g, soff_g, stat_g;

    cg_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ctrl(ctrl)
    );

    cg_sleep_sync u_sync (
        .clk(clk), .rst(rst), .async_i(cpu_sleep_i), .sync_o(slp_sync)
    );

    cg_enable_logic u_en (
        .ctrl(ctrl), .cpu_asleep(slp_sync), .en(en_vec)
    );

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_cell
        cg_clk_cell u_cell (.clk(clk), .en_i(en_vec[m]), .gclk_o(mod_clk[m]));
    end

    assign force_g = ctrl.force_off;
    assign soff_g  = ctrl.sleep_off;
    assign stat_g  = en_vec;

    always_comb begin
        case (bank_of(rd_addr))
            BANK_FORCE: rd_data = force_g[group_of(rd_addr)];
            BANK_SOFF:  rd_data = soff_g[group_of(rd_addr)];
            BANK_STAT:  rd_data = stat_g[group_of(rd_addr)];
            default:    rd_data = '0;
        endcase
    end

    p_force_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.force_off & en_vec) == '0);

    p_sleep_stop_r3: assert property (@(posedge clk) disable iff (rst)
        slp_sync |-> (ctrl.sleep_off & en_vec) == '0);

    p_wake_restore_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(slp_sync) |-> en_vec == ~ctrl.force_off);

    p_forced_stays_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(slp_sync) && $stable(ctrl.force_off)) |-> (en_vec & ctrl.force_off) == '0);

    p_sync_delay_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(slp_sync) |-> $past(cpu_sleep_i, 2));
endmodule

// File: tb/clk_gate_ctrl_tb.sv
module clk_gate_ctrl_tb;
    import cg_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic cpu_sleep_i;
    logic wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [GRP_W-1:0]  wr_data, rd_data;
    logic [NUM_MOD-1:0] mod_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NUM_MOD-1:0] m_force, m_soff;
    logic m_sleep;

    always #2 clk = ~clk;

    clk_gate_ctrl u_dut (
        .clk(clk), .rst(rst), .cpu_sleep_i(cpu_sleep_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mod_clk(mod_clk)
    );

    function automatic logic [NUM_MOD-1:0] exp_en();
        return ~m_force & ~(m_soff & {NUM_MOD{m_sleep}});
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [GRP_W-1:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [GRP_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4) m_force[a*8 +: 8] = d;
        else if (a < 8) m_soff[(a-4)*8 +: 8] = d;
    endtask

    task automatic set_sleep(input logic s);
        @(negedge clk);
        cpu_sleep_i = s;
        @(negedge clk);
        @(negedge clk);
        m_sleep = s;
    endtask

    task automatic check_all(input string req);
        logic [GRP_W-1:0] d;
        logic [NUM_MOD-1:0] st;
        for (int g = 0; g < NUM_GRP; g++) begin
            rd(ADDR_W'(8 + g), d);
            st[g*8 +: 8] = d;
        end
        check({req, " status"}, st, exp_en());
        @(posedge clk); #0.5;
        check({req, " clk high"}, mod_clk, exp_en());
        @(negedge clk); #0.5;
        check({req, " clk low"}, mod_clk, '0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [GRP_W-1:0] d;
        void'($urandom(32'd1234));
        rst = 1'b1; cpu_sleep_i = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_force = '0; m_soff = '0; m_sleep = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(ADDR_W'(a), d);
            check("R1 ctrl reg", 32'(d), 32'h0);
        end
        check_all("R1");

        // R2, R3, R4: every combination on module 5 (group 0, bit 5)
        for (int c = 0; c < 8; c++) begin
            wr(4'd0, c[0] ? 8'h20 : 8'h00);
            wr(4'd4, c[1] ? 8'h20 : 8'h00);
            set_sleep(c[2]);
            check_all(c[0] ? "R2 combo" : "R3 combo");
        end
        // R4: forced module stays off after wake with sleep-off also set
        wr(4'd1, 8'h81); wr(4'd5, 8'h81);
        set_sleep(1'b1);
        set_sleep(1'b0);
        check_all("R4");

        // R5 / R6: wake and sync delay with sleep-off on group 2
        wr(4'd1, 8'h00); wr(4'd6, 8'hF0);
        set_sleep(1'b1);
        check_all("R3 group2");
        @(negedge clk); cpu_sleep_i = 1'b0;
        @(negedge clk);
        rd(4'd10, d);
        check("R6 one edge", 32'(d), 32'h0F);
        @(negedge clk);
        m_sleep = 1'b0;
        rd(4'd10, d);
        check("R5 two edges", 32'(d), 32'hFF);
        @(negedge clk); cpu_sleep_i = 1'b1;
        @(negedge clk);
        rd(4'd10, d);
        check("R6 one edge sleep", 32'(d), 32'hFF);
        @(negedge clk);
        m_sleep = 1'b1;
        rd(4'd10, d);
        check("R6 two edges sleep", 32'(d), 32'h0F);
        set_sleep(1'b0);
        check_all("R5");

        // R7: readback of all control registers
        for (int a = 0; a < 8; a++) begin
            logic [GRP_W-1:0] v;
            v = GRP_W'($urandom);
            wr(ADDR_W'(a), v);
            rd(ADDR_W'(a), d);
            check("R7 readback", 32'(d), 32'(v));
        end
        check_all("R7");

        // R8: writes to status and unused addresses ignored
        for (int a = 8; a < 16; a++) wr(ADDR_W'(a), 8'hA5);
        for (int a = 0; a < 8; a++) begin
            rd(ADDR_W'(a), d);
            check("R8 ctrl untouched", 32'(d),
                  32'(a < 4 ? m_force[a*8 +: 8] : m_soff[(a-4)*8 +: 8]));
        end
        for (int a = 12; a < 16; a++) begin
            rd(ADDR_W'(a), d);
            check("R8 unused read", 32'(d), 32'h0);
        end
        check_all("R8");

        // R9 plus random mix
        for (int i = 0; i < 60; i++) begin
            wr(ADDR_W'($urandom_range(0, 7)), GRP_W'($urandom));
            if ($urandom_range(0, 2) == 0) set_sleep(1'(~m_sleep));
            check_all("R9 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule